// File: doc/BRIEF.md
# Merging Multi-Word Write Buffer

This block sits between a write-through cache and the next memory level. It holds a small number of entries, each covering one aligned block of several words with a per-word valid mask. Word writes from the CPU arrive on a valid/ready interface. The block address of each write is compared against every live entry. On a match the word is folded into that entry; otherwise a fresh entry is allocated. The CPU therefore moves on without waiting for memory, and neighbouring word writes reach memory as one masked block transfer.

Entries leave in the order they were allocated, over a single memory port. The same port also serves CPU reads, and a read takes it ahead of any buffered write that has not yet been offered to memory. A read whose word is still held in the buffer is answered from the buffer in the same cycle, so a read that overtakes pending writes never returns stale memory data. While the CPU keeps streaming writes into a lone, partly filled entry, that entry is held back so that more words can merge into it.

Top module: `merge_write_buffer`

## Requirements
- R1: After reset the buffer is empty: wr_ready is 1, mem_valid is 0 and rd_ready is 0.
- R2: A word write whose block address (wr_addr without its low log2(WORDS) bits) matches a live entry is merged into that entry, so several writes to one block leave as exactly one memory transfer.
- R3: A drain transfer has mem_write=1, mem_addr equal to the block's first word address (low bits zero), word w of the block in mem_wdata bits [w*DW +: DW], and mem_wmask bit w set exactly when word w was written.
- R4: Entries are drained oldest first, in allocation order.
- R5: With every entry live and no block match, wr_ready is 0; a write that matches a live entry is still accepted while the buffer is full.
- R6: Once a drain transfer is offered it holds mem_addr, mem_wdata and mem_wmask until mem_ready; a write that matches the entry being drained is stalled (wr_ready 0) until that transfer completes, and then takes a new entry.
- R7: While rd_valid is 1 and no drain has already been offered, the memory port serves the read (mem_write 0) and no buffered write reaches memory.
- R8: A read whose word is valid in a live entry returns the buffered data with rd_ready 1 in the same cycle, without a memory request.
- R9: A read not held in the buffer is sent to memory at rd_addr; rd_data is mem_rdata and rd_ready follows mem_ready.
- R10: Two writes to the same word before a drain leave only the later data in the transfer.
- R11: A single partly filled entry is not drained while wr_valid is 1; it drains once wr_valid is 0, its mask is full, or a second entry exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | CPU word write request |
| wr_ready | output | 1 | Write accepted this cycle |
| wr_addr | input | AW | Word address of the write |
| wr_data | input | DW | Write data |
| rd_valid | input | 1 | CPU read request |
| rd_ready | output | 1 | Read data valid this cycle |
| rd_addr | input | AW | Word address of the read |
| rd_data | output | DW | Read data |
| mem_valid | output | 1 | Memory request |
| mem_ready | input | 1 | Memory accepts the request |
| mem_write | output | 1 | 1 for a block write, 0 for a word read |
| mem_addr | output | AW | Word address (block-aligned on writes) |
| mem_wdata | output | WORDS*DW | Block write data |
| mem_wmask | output | WORDS | Per-word write enable |
| mem_rdata | input | DW | Read data from memory, same cycle |

## Verification
A corrupt word mask or block tag shows up at the first drain of that entry as a wrong mem_wmask or a missing or extra transfer, and the bench sweeps every mask of a four-word block to expose it. A wrong head pointer or count shows as out-of-order transfer addresses or a wr_ready that fails to fall when full, visible within a few cycles of the buffer filling. A bad forwarding match returns memory data instead of the buffered word in the very cycle of the read.

// File: rtl/merge_write_buffer.sv
module merge_write_buffer #(
  parameter int DW      = 32,
  parameter int WORDS   = 4,
  parameter int ENTRIES = 4,
  parameter int AW      = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [AW-1:0]       wr_addr,
  input  logic [DW-1:0]       wr_data,
  input  logic                rd_valid,
  output logic                rd_ready,
  input  logic [AW-1:0]       rd_addr,
  output logic [DW-1:0]       rd_data,
  output logic                mem_valid,
  input  logic                mem_ready,
  output logic                mem_write,
  output logic [AW-1:0]       mem_addr,
  output logic [WORDS*DW-1:0] mem_wdata,
  output logic [WORDS-1:0]    mem_wmask,
  input  logic [DW-1:0]       mem_rdata
);
  localparam int OFF = $clog2(WORDS);
  localparam int BW  = AW - OFF;
  localparam int PW  = $clog2(ENTRIES);
  localparam int CW  = $clog2(ENTRIES + 1);

  logic [BW-1:0]    ent_blk [ENTRIES];
  logic [DW-1:0]    ent_dat [ENTRIES][WORDS];
  logic [WORDS-1:0] ent_msk [ENTRIES];
  logic [PW-1:0]    head;
  logic [CW-1:0]    cnt;
  logic             busy;

  logic [ENTRIES-1:0] live, match;
  logic [PW-1:0]      tail, hidx;
  logic               hit, fhit, drain_offer, drain_done, wr_fire, alloc;
  logic [DW-1:0]      fdat;

  wire [OFF-1:0] wr_word = wr_addr[OFF-1:0];
  wire [BW-1:0]  wr_blk  = wr_addr[AW-1:OFF];
  wire [OFF-1:0] rd_word = rd_addr[OFF-1:0];
  wire [BW-1:0]  rd_blk  = rd_addr[AW-1:OFF];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    wire [PW-1:0] rel = PW'(i) - head;
    assign live[i]  = CW'(rel) < cnt;
    assign match[i] = live[i] && (ent_blk[i] == wr_blk);
  end

  always_comb begin
    hidx = '0;
    fhit = 1'b0;
    fdat = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) hidx = PW'(i);
      if (live[i] && ent_blk[i] == rd_blk && ent_msk[i][rd_word]) begin
        fhit = 1'b1;
        fdat = ent_dat[i][rd_word];
      end
    end
  end

  assign hit  = |match;
  assign tail = head + PW'(cnt);

  assign drain_offer = busy || (cnt != '0 && !rd_valid &&
                       (cnt > CW'(1) || (&ent_msk[head]) || !wr_valid));
  assign drain_done  = drain_offer && mem_ready;

  assign wr_ready = hit ? !(hidx == head && drain_offer) : (cnt != CW'(ENTRIES));
  assign wr_fire  = wr_valid && wr_ready;
  assign alloc    = wr_fire && !hit;

  assign mem_write = drain_offer;
  assign mem_valid = drain_offer || (rd_valid && !fhit);
  assign mem_addr  = drain_offer ? {ent_blk[head], {OFF{1'b0}}} : rd_addr;
  assign mem_wmask = ent_msk[head];
  for (genvar w = 0; w < WORDS; w++) begin : g_wd
    assign mem_wdata[w*DW +: DW] = ent_dat[head][w];
  end

  assign rd_data  = fhit ? fdat : mem_rdata;
  assign rd_ready = rd_valid && (fhit || (!drain_offer && mem_ready));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      for (int i = 0; i < ENTRIES; i++) ent_msk[i] <= '0;
    end else begin
      busy <= drain_offer && !mem_ready;
      if (drain_done) head <= head + PW'(1);
      cnt <= cnt + CW'(alloc) - CW'(drain_done);
      for (int i = 0; i < ENTRIES; i++) begin
        if (wr_fire && hit && match[i]) ent_msk[i][wr_word] <= 1'b1;
        else if (alloc && PW'(i) == tail) ent_msk[i] <= WORDS'(1) << wr_word;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (wr_fire && ((hit && match[i]) || (!hit && PW'(i) == tail))) begin
        ent_dat[i][wr_word] <= wr_data;
        if (!hit) ent_blk[i] <= wr_blk;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(ENTRIES)) else $error("count overflow"); // R5
  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(match) <= 1) else $error("block held twice"); // R2
  AST_MASK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write) |-> (mem_wmask != '0)) else $error("empty drain"); // R3
  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write && !mem_ready) |=> (mem_valid && mem_write &&
      $stable(mem_addr) && $stable(mem_wmask) && $stable(mem_wdata)))
    else $error("drain changed before accept"); // R6
  AST_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_valid) && rd_valid && !$past(mem_valid && mem_write)) |-> !(mem_valid && mem_write))
    else $error("drain overtook read"); // R7
endmodule

// File: tb/merge_write_buffer_test.sv
module merge_write_buffer_test;
  localparam int DW = 32, WORDS = 4, ENTRIES = 4, AW = 6;

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, rd_valid = 0, mem_ready = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, rd_ready, mem_valid, mem_write;
  logic [DW-1:0] rd_data, mem_rdata;
  logic [AW-1:0] mem_addr;
  logic [WORDS*DW-1:0] mem_wdata;
  logic [WORDS-1:0] mem_wmask;

  logic [DW-1:0] tbm [64];
  logic [AW-1:0] lg_addr [64];
  logic [WORDS-1:0] lg_mask [64];
  int nx = 0, checks = 0, failures = 0;

  always #5 clk = ~clk;

  merge_write_buffer #(.DW(DW), .WORDS(WORDS), .ENTRIES(ENTRIES), .AW(AW)) uut (
    .clk, .rst_n, .wr_valid, .wr_ready, .wr_addr, .wr_data,
    .rd_valid, .rd_ready, .rd_addr, .rd_data,
    .mem_valid, .mem_ready, .mem_write, .mem_addr, .mem_wdata, .mem_wmask, .mem_rdata);

  assign mem_rdata = tbm[mem_addr];

  always @(posedge clk) begin
    if (rst_n && mem_valid && mem_write && mem_ready) begin
      for (int w = 0; w < WORDS; w++)
        if (mem_wmask[w]) tbm[int'(mem_addr) + w] = mem_wdata[w*DW +: DW];
      if (nx < 64) begin
        lg_addr[nx] = mem_addr;
        lg_mask[nx] = mem_wmask;
      end
      nx = nx + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    wr_valid = 1; wr_addr = AW'(a); wr_data = d;
    #1;
    while (!wr_ready) begin @(negedge clk); #1; end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    wr_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int base;
    for (int i = 0; i < 64; i++) tbm[i] = 32'h5000_0000 + i;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(wr_ready == 1, "R1 wr_ready", 32'(wr_ready), 1);
    chk(mem_valid == 0, "R1 mem_valid", 32'(mem_valid), 0);
    chk(rd_ready == 0, "R1 rd_ready", 32'(rd_ready), 0);
    @(negedge clk);

    // R2 R3 R11: every nonzero mask of one block, one transfer each
    mem_ready = 1;
    for (int m = 1; m < 16; m++) begin
      base = nx;
      for (int w = 0; w < WORDS; w++)
        if (m[w]) wr(m*4 + w, 32'hA000_0000 | (m << 8) | w);
      idle(4);
      chk(nx == base + 1, "R2 single transfer", nx - base, 1);
      chk(lg_mask[base] == 4'(m), "R3 mask", 32'(lg_mask[base]), m);
      chk(lg_addr[base] == AW'(m*4), "R3 addr", 32'(lg_addr[base]), m*4);
      for (int w = 0; w < WORDS; w++)
        if (m[w]) chk(tbm[m*4+w] == (32'hA000_0000 | (m << 8) | w), "R3 data",
                      tbm[m*4+w], 32'hA000_0000 | (m << 8) | w);
    end

    // R10: last write to a word wins
    base = nx;
    wr(14, 32'h1111_0001); wr(14, 32'h2222_0002); wr(12, 32'h3333_0003);
    idle(4);
    chk(nx == base + 1, "R10 one transfer", nx - base, 1);
    chk(lg_mask[base] == 4'b0101, "R10 mask", 32'(lg_mask[base]), 5);
    chk(tbm[14] == 32'h2222_0002, "R10 data", tbm[14], 32'h2222_0002);

    // R6: merge into entry being drained stalls, then takes a new entry
    mem_ready = 0; base = nx;
    wr(24, 32'hD000_0000);
    idle(1); #1;
    chk(mem_valid && mem_write, "R11 drain after wr_valid drops", 32'(mem_valid), 1);
    wr_valid = 1; wr_addr = 25; wr_data = 32'hD000_0001; #1;
    chk(wr_ready == 0, "R6 stall on draining entry", 32'(wr_ready), 0);
    @(negedge clk); #1;
    chk(wr_ready == 0, "R6 still stalled", 32'(wr_ready), 0);
    chk(mem_addr == 24 && mem_wmask == 4'b0001, "R6 drain held", 32'(mem_addr), 24);
    mem_ready = 1; #1;
    chk(wr_ready == 0, "R6 stalled in accept cycle", 32'(wr_ready), 0);
    @(negedge clk);
    wr(25, 32'hD000_0001);
    idle(4);
    chk(nx == base + 2, "R6 two transfers", nx - base, 2);
    chk(lg_mask[base] == 4'b0001 && lg_mask[base+1] == 4'b0010, "R6 masks",
        {lg_mask[base], lg_mask[base+1]}, 8'h12);

    // R5 R4: fill, stall on new block, merge while full, oldest-first drain
    mem_ready = 0; base = nx;
    wr(32, 32'hB8); wr(36, 32'hB9); wr(40, 32'hBA); wr(44, 32'hBB);
    wr_addr = 48; #1;
    chk(wr_ready == 0, "R5 full stall", 32'(wr_ready), 0);
    wr_addr = 41; wr_data = 32'hBA1; #1;
    chk(wr_ready == 1, "R5 merge while full", 32'(wr_ready), 1);
    @(negedge clk);
    wr_addr = 33; #1;
    chk(wr_ready == 0, "R6 head merge stalled", 32'(wr_ready), 0);
    wr_valid = 0; mem_ready = 1;
    repeat (8) @(negedge clk);
    chk(nx == base + 4, "R4 four transfers", nx - base, 4);
    for (int k = 0; k < 4; k++)
      chk(lg_addr[base+k] == AW'(32 + 4*k), "R4 order", 32'(lg_addr[base+k]), 32 + 4*k);
    chk(lg_mask[base+2] == 4'b0011, "R5 merged mask", 32'(lg_mask[base+2]), 3);
    chk(tbm[41] == 32'hBA1, "R5 merged data", tbm[41], 32'hBA1);
    wr(48, 32'hBC);
    idle(4);
    chk(lg_addr[nx-1] == 48, "R5 later alloc", 32'(lg_addr[nx-1]), 48);

    // R8 R9: forward from buffer, miss goes to memory
    mem_ready = 0;
    wr(52, 32'hF00D_0000);
    wr_valid = 0; rd_valid = 1; rd_addr = 52; #1;
    chk(rd_ready == 1, "R8 rd_ready", 32'(rd_ready), 1);
    chk(rd_data == 32'hF00D_0000, "R8 forwarded data", rd_data, 32'hF00D_0000);
    chk(mem_valid == 0, "R8 no memory request", 32'(mem_valid), 0);
    rd_addr = 53; #1;
    chk(mem_valid && !mem_write && mem_addr == 53, "R9 read request", 32'(mem_addr), 53);
    chk(rd_ready == 0, "R9 waits for memory", 32'(rd_ready), 0);
    mem_ready = 1; #1;
    chk(rd_ready == 1 && rd_data == tbm[53], "R9 memory data", rd_data, tbm[53]);
    @(negedge clk);
    rd_valid = 0;
    repeat (4) @(negedge clk);
    chk(tbm[52] == 32'hF00D_0000, "R8 drained later", tbm[52], 32'hF00D_0000);

    // R7: read holds the port ahead of a pending write
    rd_valid = 1; rd_addr = 2;
    wr(58, 32'hCAFE_0002);
    wr_valid = 0; base = nx;
    for (int c = 0; c < 3; c++) begin
      #1;
      chk(mem_valid && !mem_write, "R7 read owns port", 32'(mem_write), 0);
      chk(rd_ready && rd_data == tbm[2], "R7 read data", rd_data, tbm[2]);
      @(negedge clk);
    end
    chk(nx == base, "R7 no write during read", nx - base, 0);
    rd_valid = 0;
    repeat (4) @(negedge clk);
    chk(nx == base + 1 && lg_addr[base] == 56, "R7 write after read", 32'(lg_addr[base]), 56);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule